// File: doc/BRIEF.md
# Linked-List Coherence Home Directory

This block is the home-side directory controller for a coherence scheme where the list of sharers of a memory line is spread across the caches themselves. For every line it owns, the home keeps only a line state and the node ID of the head of the sharing list. Every requester that is served becomes the new head. When a list already exists, the home returns the old head's ID so that the requester can link itself in front of it. The home never walks the list and never looks at the detailed cache state held at the head.

Requests arrive one per cycle over a valid/ready handshake. Each carries an operation (read, ownership request or writeback), the requester node ID, a line index and writeback data. Each accepted request produces exactly one registered reply one cycle later. A reply can carry line data, the old head ID, a grant, or a retry. The line data is held in a small local array inside the block. Requests are serialized in the order the home accepts them, so every request sees the full effect of the one accepted before it.

Top module: `hdir_home`

## Requirements
- R1: After reset every line is in the HOME state with stored data zero, `rsp_valid` is low, and the first read of any line returns data zero.
- R2: A read (op 0) of a line in HOME replies code 0 (data) with the line data and `rsp_head` zero. The line moves to FRESH with the requester as head.
- R3: A read of a line in FRESH replies code 1 (data plus head) with the line data and the previous head in `rsp_head`. The requester becomes head and the line stays FRESH.
- R4: A read of a line in GONE replies code 2 (head only) with the previous head and `rsp_data` zero. The requester becomes head and the line stays GONE.
- R5: An ownership request (op 1) from the current head of a FRESH line replies code 3 (grant) with zero head and data. The line moves to GONE and the head is unchanged.
- R6: Any other ownership request also leaves the line GONE with the requester as head. From HOME the reply is code 0 with the data. From FRESH it is code 1 with the data and the old head. From GONE it is code 2 with the old head, except that a request from the current head of a GONE line is answered with code 3 and changes nothing.
- R7: A writeback (op 2) from the current head of a FRESH or GONE line replies code 3 and returns the line to HOME. Writeback data is stored only when the line was GONE.
- R8: A writeback from a node that is not the current head, a writeback to a line in HOME, and the unused op 3 are all answered with code 4 (retry) and leave state, head and data unchanged.
- R9: Requests to the same line on consecutive cycles are applied in acceptance order. Each one sees the state left by the one before it.
- R10: Every accepted request gives exactly one reply, valid on the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the reply holds stable and `req_ready` is low.
- R11: `rsp_node` returns the requester ID of the request that the reply answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 read, 1 ownership, 2 writeback, 3 unused |
| req_node | input | NODE_W | Requester node ID |
| req_line | input | LINE_W | Line index |
| req_data | input | DATA_W | Writeback data |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply consumed this cycle when valid |
| rsp_code | output | 3 | 0 data, 1 data plus head, 2 head only, 3 grant, 4 retry |
| rsp_node | output | NODE_W | Requester the reply is addressed to |
| rsp_head | output | NODE_W | Previous head for codes 1 and 2, else zero |
| rsp_data | output | DATA_W | Line data for codes 0 and 1, else zero |

## Verification
The bench builds the block with 6-bit node IDs, a 2-bit line index and 16-bit data. With only four lines, random traffic hits the same line on consecutive cycles very often. Requester IDs are drawn mostly from a handful of nodes plus the all-ones ID, so head matches and head mismatches both occur often. Together these make every state-by-operation case common, including head-match ownership, stale writebacks and back-to-back serialization. Random back-pressure on the reply side exercises the stall path.

// File: rtl/hdir_pkg.sv
package hdir_pkg;

  typedef enum logic [1:0] {
    LS_HOME  = 2'd0,
    LS_FRESH = 2'd1,
    LS_GONE  = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_OWN  = 2'd1,
    OP_WB   = 2'd2,
    OP_RSV  = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    RC_DATA      = 3'd0,
    RC_DATA_HEAD = 3'd1,
    RC_HEAD      = 3'd2,
    RC_GRANT     = 3'd3,
    RC_RETRY     = 3'd4
  } rsp_code_e;

endpackage

// File: rtl/hdir_decide.sv
module hdir_decide
  import hdir_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int DATA_W = 32
) (
  input  logic [1:0]        op,
  input  logic [NODE_W-1:0] node,
  input  logic [DATA_W-1:0] wdata,
  input  line_state_e       cur_state,
  input  logic [NODE_W-1:0] cur_head,
  input  logic [DATA_W-1:0] cur_data,
  output logic              upd,
  output line_state_e       nxt_state,
  output logic [NODE_W-1:0] nxt_head,
  output logic [DATA_W-1:0] nxt_data,
  output rsp_code_e         code,
  output logic [NODE_W-1:0] rhead,
  output logic [DATA_W-1:0] rdata
);

  logic is_head;
  assign is_head = (node == cur_head);

  always_comb begin
    upd       = 1'b0;
    nxt_state = cur_state;
    nxt_head  = cur_head;
    nxt_data  = cur_data;
    code      = RC_RETRY;
    rhead     = '0;
    rdata     = '0;
    unique case (op)
      OP_READ: begin
        unique case (cur_state)
          LS_HOME: begin
            upd = 1'b1; nxt_state = LS_FRESH; nxt_head = node;
            code = RC_DATA; rdata = cur_data;
          end
          LS_FRESH: begin
            upd = 1'b1; nxt_head = node;
            code = RC_DATA_HEAD; rdata = cur_data; rhead = cur_head;
          end
          LS_GONE: begin
            upd = 1'b1; nxt_head = node;
            code = RC_HEAD; rhead = cur_head;
          end
          default: code = RC_RETRY;
        endcase
      end
      OP_OWN: begin
        unique case (cur_state)
          LS_HOME: begin
            upd = 1'b1; nxt_state = LS_GONE; nxt_head = node;
            code = RC_DATA; rdata = cur_data;
          end
          LS_FRESH: begin
            upd = 1'b1; nxt_state = LS_GONE;
            if (is_head) begin
              code = RC_GRANT;
            end else begin
              nxt_head = node;
              code = RC_DATA_HEAD; rdata = cur_data; rhead = cur_head;
            end
          end
          LS_GONE: begin
            if (is_head) begin
              code = RC_GRANT;
            end else begin
              upd = 1'b1; nxt_head = node;
              code = RC_HEAD; rhead = cur_head;
            end
          end
          default: code = RC_RETRY;
        endcase
      end
      OP_WB: begin
        if (is_head && (cur_state == LS_FRESH || cur_state == LS_GONE)) begin
          upd = 1'b1; nxt_state = LS_HOME; nxt_head = '0;
          if (cur_state == LS_GONE) nxt_data = wdata;
          code = RC_GRANT;
        end
      end
      default: code = RC_RETRY;
    endcase
  end

endmodule

// File: rtl/hdir_line_store.sv
module hdir_line_store
  import hdir_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int LINE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_idx,
  input  line_state_e       wr_state,
  input  logic [NODE_W-1:0] wr_head,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LINE_W-1:0] rd_idx,
  output line_state_e       rd_state,
  output logic [NODE_W-1:0] rd_head,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LINES = 1 << LINE_W;

  line_state_e       st_q   [LINES];
  logic [NODE_W-1:0] head_q [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              en;
    line_state_e       st_d;
    logic [NODE_W-1:0] head_d;
    logic [DATA_W-1:0] data_d;

    assign en = wr_en && (wr_idx == LINE_W'(g));

    always_comb begin
      st_d   = st_q[g];
      head_d = head_q[g];
      data_d = data_q[g];
      if (en) begin
        st_d   = wr_state;
        head_d = wr_head;
        data_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]   <= LS_HOME;
        head_q[g] <= '0;
        data_q[g] <= '0;
      end else begin
        st_q[g]   <= st_d;
        head_q[g] <= head_d;
        data_q[g] <= data_d;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_head  = head_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/hdir_rsp_reg.sv
module hdir_rsp_reg
  import hdir_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  rsp_code_e         in_code,
  input  logic [NODE_W-1:0] in_node,
  input  logic [NODE_W-1:0] in_head,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output rsp_code_e         out_code,
  output logic [NODE_W-1:0] out_node,
  output logic [NODE_W-1:0] out_head,
  output logic [DATA_W-1:0] out_data
);

  logic              valid_d;
  rsp_code_e         code_d;
  logic [NODE_W-1:0] node_d, head_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = out_valid;
    code_d  = out_code;
    node_d  = out_node;
    head_d  = out_head;
    data_d  = out_data;
    if (take) valid_d = 1'b0;
    if (load) begin
      valid_d = 1'b1;
      code_d  = in_code;
      node_d  = in_node;
      head_d  = in_head;
      data_d  = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= RC_RETRY;
      out_node  <= '0;
      out_head  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_d;
      out_code  <= code_d;
      out_node  <= node_d;
      out_head  <= head_d;
      out_data  <= data_d;
    end
  end

endmodule

// File: rtl/hdir_home.sv
module hdir_home
  import hdir_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int LINE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [NODE_W-1:0] rsp_node,
  output logic [NODE_W-1:0] rsp_head,
  output logic [DATA_W-1:0] rsp_data
);

  // reset released synchronously
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic live;
  assign live = rst_sync_q[1];

  logic fire, take;
  assign req_ready = live && (!rsp_valid || rsp_ready);
  assign fire      = req_valid && req_ready;
  assign take      = rsp_valid && rsp_ready;

  line_state_e       cur_state, nxt_state;
  logic [NODE_W-1:0] cur_head, nxt_head, dec_head;
  logic [DATA_W-1:0] cur_data, nxt_data, dec_data;
  logic              dec_upd;
  rsp_code_e         dec_code, out_code;

  hdir_line_store #(.NODE_W(NODE_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fire && dec_upd),
    .wr_idx   (req_line),
    .wr_state (nxt_state),
    .wr_head  (nxt_head),
    .wr_data  (nxt_data),
    .rd_idx   (req_line),
    .rd_state (cur_state),
    .rd_head  (cur_head),
    .rd_data  (cur_data)
  );

  hdir_decide #(.NODE_W(NODE_W), .DATA_W(DATA_W)) u_decide (
    .op        (req_op),
    .node      (req_node),
    .wdata     (req_data),
    .cur_state (cur_state),
    .cur_head  (cur_head),
    .cur_data  (cur_data),
    .upd       (dec_upd),
    .nxt_state (nxt_state),
    .nxt_head  (nxt_head),
    .nxt_data  (nxt_data),
    .code      (dec_code),
    .rhead     (dec_head),
    .rdata     (dec_data)
  );

  hdir_rsp_reg #(.NODE_W(NODE_W), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .take      (take),
    .in_code   (dec_code),
    .in_node   (req_node),
    .in_head   (dec_head),
    .in_data   (dec_data),
    .out_valid (rsp_valid),
    .out_code  (out_code),
    .out_node  (rsp_node),
    .out_head  (rsp_head),
    .out_data  (rsp_data)
  );

  assign rsp_code = out_code;

endmodule

// File: rtl/hdir_home_chk.sv
module hdir_home_chk #(
  parameter int NODE_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [NODE_W-1:0] req_node,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        rsp_code,
  input logic [NODE_W-1:0] rsp_node,
  input logic [NODE_W-1:0] rsp_head,
  input logic [DATA_W-1:0] rsp_data
);

  AST_RSP_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_node)
      && $stable(rsp_head) && $stable(rsp_data)); // R10

  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R10

  AST_NODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_node == $past(req_node)); // R11

  AST_RETRY_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_op == 2'd0 || req_op == 2'd1) |=> rsp_code != 3'd4); // R8

  AST_READ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'd0 |=> rsp_code <= 3'd2); // R2

  AST_HEAD_ONLY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == 3'd2 |-> rsp_data == '0); // R4

endmodule

bind hdir_home hdir_home_chk #(.NODE_W(NODE_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_node  (req_node),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .rsp_node  (rsp_node),
  .rsp_head  (rsp_head),
  .rsp_data  (rsp_data)
);

// File: tb/hdir_home_tb.sv
`timescale 1ns/1ps
module hdir_home_tb;

  localparam int NODE_W = 6;
  localparam int LINE_W = 2;
  localparam int DATA_W = 16;
  localparam int LINES  = 1 << LINE_W;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, rsp_valid, rsp_ready;
  logic [1:0] req_op;
  logic [NODE_W-1:0] req_node, rsp_node, rsp_head;
  logic [LINE_W-1:0] req_line;
  logic [DATA_W-1:0] req_data, rsp_data;
  logic [2:0] rsp_code;

  always #2 clk = ~clk;

  hdir_home #(.NODE_W(NODE_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_node(req_node), .req_line(req_line), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_node(rsp_node), .rsp_head(rsp_head), .rsp_data(rsp_data)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model: 0 HOME, 1 FRESH, 2 GONE
  int m_state [LINES];
  int m_head  [LINES];
  int m_data  [LINES];
  bit m_seen  [LINES];
  bit m_rv = 0;
  int m_code, m_node, m_rhead, m_rdata;
  string m_tag = "R1";
  bit last_fire = 0;
  int last_line = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input int op, input int node, input int line, input int wd);
    int st, hd;
    string tag;
    st = m_state[line]; hd = m_head[line];
    m_node = node; m_rhead = 0; m_rdata = 0; m_code = 4; tag = "R8";
    if (op == 0) begin
      m_head[line] = node;
      if (st == 0) begin m_code = 0; m_rdata = m_data[line]; m_state[line] = 1; tag = "R2"; end
      else if (st == 1) begin m_code = 1; m_rdata = m_data[line]; m_rhead = hd; tag = "R3"; end
      else begin m_code = 2; m_rhead = hd; tag = "R4"; end
    end else if (op == 1) begin
      tag = "R6";
      if (st == 0) begin m_code = 0; m_rdata = m_data[line]; m_state[line] = 2; m_head[line] = node; end
      else if (st == 1 && hd == node) begin m_code = 3; m_state[line] = 2; tag = "R5"; end
      else if (st == 1) begin
        m_code = 1; m_rdata = m_data[line]; m_rhead = hd; m_state[line] = 2; m_head[line] = node;
      end
      else if (hd == node) m_code = 3;
      else begin m_code = 2; m_rhead = hd; m_head[line] = node; end
    end else if (op == 2 && st != 0 && hd == node) begin
      m_code = 3; tag = "R7";
      if (st == 2) m_data[line] = wd;
      m_state[line] = 0; m_head[line] = 0;
    end
    if (!m_seen[line] && op == 0) tag = "R1";
    if (last_fire && last_line == line) tag = "R9";
    m_seen[line] = 1;
    m_tag = tag;
  endtask

  task automatic cycle(input bit v, input int op, input int node, input int line,
                       input int wd, input bit rdy);
    bit fire;
    @(negedge clk);
    chk("R10", "rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv && rsp_valid) begin
      chk(m_tag, "rsp_code", int'(rsp_code), m_code);
      chk(m_tag, "rsp_head", int'(rsp_head), m_rhead);
      chk(m_tag, "rsp_data", int'(rsp_data), m_rdata);
      chk("R11", "rsp_node", int'(rsp_node), m_node);
    end
    req_valid = v; req_op = 2'(op); req_node = NODE_W'(node);
    req_line = LINE_W'(line); req_data = DATA_W'(wd); rsp_ready = rdy;
    #1;
    chk("R10", "req_ready", int'(req_ready), int'(!m_rv || rdy));
    fire = v && (!m_rv || rdy);
    if (m_rv && rdy) m_rv = 0;
    else if (m_rv) m_tag = "R10";
    if (fire) begin
      model(op, node, line, wd);
      m_rv = 1;
    end
    last_fire = fire;
    last_line = line;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_state[i] = 0; m_head[i] = 0; m_data[i] = 0; m_seen[i] = 0;
    end
    req_valid = 0; req_op = 0; req_node = 0; req_line = 0; req_data = 0; rsp_ready = 1;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    // directed walk on line 1
    cycle(1, 0, 5, 1, 0, 1);        // R2 HOME read
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 0, 9, 1, 0, 1);        // R3 FRESH read
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 1, 9, 1, 0, 1);        // R5 head ownership
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 0, 3, 1, 0, 1);        // R4 GONE read
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 2, 9, 1, 16'hBEEF, 1); // R8 stale writeback
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 2, 3, 1, 16'hBEEF, 1); // R7 head writeback
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 0, 7, 1, 0, 1);        // R2 data written back
    cycle(0, 0, 0, 0, 0, 1);
    cycle(1, 1, 8, 1, 0, 1);        // R6 ownership from non-head
    cycle(1, 1, 8, 1, 0, 1);        // R6/R9 owner again gets grant
    cycle(1, 1, 2, 2, 0, 1);        // R6 HOME ownership
    cycle(1, 3, 2, 2, 0, 1);        // R8 unused op
    cycle(1, 0, 4, 2, 0, 0);        // R10 stall
    cycle(1, 0, 4, 2, 0, 0);
    cycle(1, 0, 4, 2, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int nd;
      nd = ($urandom % 8 == 0) ? 63 : int'($urandom % 4);
      cycle(($urandom % 4) != 0, int'($urandom % 4), nd, int'($urandom % LINES),
            int'($urandom % 65536), ($urandom % 4) != 0);
    end
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule